// File: doc/BRIEF.md
# Per-Lane Linear Frequency Ramp Generator

This block drives the frequency side of a chirp synthesizer whose output samples are produced by several parallel lanes running on a slow clock. At every slow clock it emits one tuning word per lane. Lane `i` at slow-time index `m` gets `K0 ± (LANES·m + i)·H`, where `K0` is the start tuning word and `H` is the half-step magnitude. One shared accumulator advances by `LANES·H` per slow clock. Each lane adds its own fixed offset `i·H`. Read in lane order, the words therefore step once per fast sample, so the frequency moves at the full sampling rate. Phase accumulation and the waveform lookup take place downstream.

A ramp begins when `start_i` is seen high with a nonzero `ramp_len_i`. At that edge the block captures the start word, the half-step magnitude, the direction bit and the length. The accumulator is cleared and `active_o` rises. After `ramp_len_i` slow clocks the flag drops. The words then stay at their last values until the next accepted start. All arithmetic wraps modulo 2^N.

Top module: `chirp_lane_ramp`

## Requirements
- R1: After reset `active_o` is 0 and every lane word on `tw_o` is 0.
- R2: In the cycle after an accepted start (`start_i`=1 and `ramp_len_i`≠0 at a rising edge), `active_o` is 1 and lane `i` (bits `i*N +: N` of `tw_o`) equals `K0 + i·H` when `step_neg_i` was 0.
- R3: Each further active clock adds `LANES·H` to every lane, so lane `i` at index `m` equals `K0 + (LANES·m + i)·H`. Adjacent lanes always differ by exactly `H`.
- R4: With `step_neg_i`=1 captured at the start, lane `i` equals `K0 − (LANES·m + i)·H`, giving a falling frequency.
- R5: `active_o` stays high for exactly `ramp_len_i` cycles (indices 0 to M−1) and then goes low.
- R6: Once a ramp ends, `tw_o` holds the words of index M−1 unchanged until the next accepted start.
- R7: An accepted start during an active ramp restarts the ramp at index 0 with the newly captured values.
- R8: A start with `ramp_len_i`=0 is ignored: `active_o` and `tw_o` keep their values.
- R9: Tuning-word arithmetic wraps modulo 2^N, with no saturation.
- R10: Changes on `k0_i`, `half_step_i`, `step_neg_i` and `ramp_len_i` have no effect unless they come with an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow (per-group) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Ramp start pulse |
| k0_i | input | N | Start tuning word K0 |
| half_step_i | input | N | Half-step magnitude H = abs(Ks)/2 |
| step_neg_i | input | 1 | 1 selects a falling ramp (subtract) |
| ramp_len_i | input | LEN_W | Ramp length M in slow clocks |
| tw_o | output | LANES*N | Packed lane tuning words, lane i at bits i*N +: N |
| active_o | output | 1 | High while a ramp is running |

## Verification
The assertions take the inputs as meaningful only in the cycle where `start_i` is high. They assume that a nonzero length yields the exact cycle count, and that the direction bit and magnitude stay fixed for the whole ramp because they were captured at the start. The stimulus drives all inputs half a period away from the active edge. It moves the parameter inputs to unrelated values outside start cycles. It keeps lengths small enough that every ramp ends well inside the run, and uses start words near 2^N to force wrap.

// File: rtl/clr_pkg.sv
`timescale 1ns/1ps
package clr_pkg;
  localparam int unsigned MAX_W = 64;
  typedef logic [MAX_W-1:0] word_t;

  // unsigned product by a small constant factor, modulo 2^64
  function automatic word_t scale(word_t v, int unsigned k);
    return v * word_t'(k);
  endfunction

  // base plus or minus offset, modulo 2^64 (callers truncate to N)
  function automatic word_t lane_word(word_t base, word_t off, logic neg);
    return neg ? (base - off) : (base + off);
  endfunction
endpackage

// File: rtl/clr_seq.sv
`timescale 1ns/1ps
module clr_seq #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             load_o,
  output logic             step_o,
  output logic             run_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             last;

  assign load_o = start_i && (len_i != '0);
  assign last   = (cnt_q == (len_q - 1'b1));
  assign step_o = run_o && !last && !load_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_o <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else if (load_o) begin
      run_o <= 1'b1;
      cnt_q <= '0;
      len_q <= len_i;
    end else if (run_o) begin
      if (last) run_o <= 1'b0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: the index never reaches the captured length while running
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (cnt_q < len_q));
  // R5: the final index ends the ramp
  p_len_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && last && !load_o) |=> !run_o);
  // R2: accepted start enters index 0 of a running ramp
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (run_o && cnt_q == '0));
  // R8: zero-length start from idle leaves the block idle
  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_i == '0 && !run_o) |=> !run_o);
endmodule

// File: rtl/clr_accum.sv
`timescale 1ns/1ps
module clr_accum
  import clr_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter int unsigned LANES = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [N-1:0] k0_i,
  input  logic [N-1:0] half_i,
  input  logic         neg_i,
  output logic [N-1:0] k0_o,
  output logic [N-1:0] half_o,
  output logic         neg_o,
  output logic [N-1:0] acc_o
);
  localparam bit          POW2  = ((LANES & (LANES - 1)) == 0);
  localparam int unsigned SHIFT = $clog2(LANES);

  logic [N-1:0] stride;

  generate
    if (POW2) begin : g_shift
      assign stride = half_o << SHIFT;
    end else begin : g_mult
      assign stride = N'(scale(word_t'(half_o), LANES));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k0_o   <= '0;
      half_o <= '0;
      neg_o  <= 1'b0;
      acc_o  <= '0;
    end else if (load_i) begin
      k0_o   <= k0_i;
      half_o <= half_i;
      neg_o  <= neg_i;
      acc_o  <= '0;
    end else if (step_i) begin
      acc_o  <= acc_o + stride;
    end
  end

  // R3: one group step adds LANES half-steps, wrapping at 2^N (R9)
  p_acc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> acc_o == N'($past(acc_o) + N'(scale(word_t'($past(half_o)), LANES))));
  // R2: a start clears the group term
  p_acc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> acc_o == '0);
  // R10: no load and no step leaves all captured state alone
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> ($stable(acc_o) && $stable(k0_o) && $stable(half_o) && $stable(neg_o)));
endmodule

// File: rtl/clr_lane.sv
`timescale 1ns/1ps
module clr_lane
  import clr_pkg::*;
#(
  parameter int unsigned N   = 32,
  parameter int unsigned IDX = 0
) (
  input  logic [N-1:0] k0_i,
  input  logic [N-1:0] half_i,
  input  logic         neg_i,
  input  logic [N-1:0] acc_i,
  output logic [N-1:0] word_o
);
  logic [N-1:0] lane_off;
  logic [N-1:0] total_off;

  assign lane_off  = N'(scale(word_t'(half_i), IDX));
  assign total_off = acc_i + lane_off;
  assign word_o    = N'(lane_word(word_t'(k0_i), word_t'(total_off), neg_i));
endmodule

// File: rtl/chirp_lane_ramp.sv
`timescale 1ns/1ps
module chirp_lane_ramp #(
  parameter int unsigned N     = 32,
  parameter int unsigned LANES = 8,
  parameter int unsigned LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [N-1:0]       k0_i,
  input  logic [N-1:0]       half_step_i,
  input  logic               step_neg_i,
  input  logic [LEN_W-1:0]   ramp_len_i,
  output logic [LANES*N-1:0] tw_o,
  output logic               active_o
);
  logic         load_ev;
  logic         step_ev;
  logic [N-1:0] k0_q;
  logic [N-1:0] half_q;
  logic         neg_q;
  logic [N-1:0] acc_q;
  logic [N-1:0] lane_w [LANES];

  clr_seq #(.LEN_W(LEN_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .len_i   (ramp_len_i),
    .load_o  (load_ev),
    .step_o  (step_ev),
    .run_o   (active_o)
  );

  clr_accum #(.N(N), .LANES(LANES)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_ev),
    .step_i (step_ev),
    .k0_i   (k0_i),
    .half_i (half_step_i),
    .neg_i  (step_neg_i),
    .k0_o   (k0_q),
    .half_o (half_q),
    .neg_o  (neg_q),
    .acc_o  (acc_q)
  );

  generate
    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
      clr_lane #(.N(N), .IDX(g)) u_lane (
        .k0_i   (k0_q),
        .half_i (half_q),
        .neg_i  (neg_q),
        .acc_i  (acc_q),
        .word_o (lane_w[g])
      );
      assign tw_o[g*N +: N] = lane_w[g];

      if (g > 0) begin : g_gap
        logic [N-1:0] gap;
        logic [N-1:0] gap_exp;
        assign gap     = lane_w[g] - lane_w[g-1];
        assign gap_exp = neg_q ? (N'(0) - half_q) : half_q;
        // R3/R4: neighbouring lanes sit exactly one half-step apart
        p_lane_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
          gap == gap_exp);
      end
    end
  endgenerate

  // R6: with no ramp and no accepted start, the words do not move
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !load_ev) |=> $stable(tw_o));
  // R1: idle after reset means lane 0 carries the captured start word
  p_idle_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && acc_q == '0) |-> (lane_w[0] == k0_q));
endmodule

// File: tb/chirp_lane_ramp_bench.sv
`timescale 1ns/1ps
module chirp_lane_ramp_bench;
  localparam int N = 32, LANES = 8, LEN_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n;
  logic               start_i;
  logic [N-1:0]       k0_i, half_step_i;
  logic               step_neg_i;
  logic [LEN_W-1:0]   ramp_len_i;
  logic [LANES*N-1:0] tw_o;
  logic               active_o;

  chirp_lane_ramp #(.N(N), .LANES(LANES), .LEN_W(LEN_W)) u_chirp_lane_ramp (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .k0_i(k0_i),
    .half_step_i(half_step_i), .step_neg_i(step_neg_i), .ramp_len_i(ramp_len_i),
    .tw_o(tw_o), .active_o(active_o));

  int checks = 0, failures = 0;
  logic               q_act[$];
  logic [LANES*N-1:0] q_tw[$];
  string              q_tag[$];

  // reference model state
  logic [N-1:0]     m_k0 = '0, m_h = '0;
  logic             m_neg = 1'b0, m_run = 1'b0;
  logic [LEN_W-1:0] m_len = '0, m_idx = '0;

  function automatic logic [LANES*N-1:0] model_words();
    logic [LANES*N-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      logic [63:0] prod;
      prod = (64'(LANES) * 64'(m_idx) + 64'(i)) * 64'(m_h);
      r[i*N +: N] = m_neg ? (m_k0 - prod[N-1:0]) : (m_k0 + prod[N-1:0]);
    end
    return r;
  endfunction

  task automatic drive(input logic st, input logic [N-1:0] k0, input logic [N-1:0] h,
                       input logic neg, input logic [LEN_W-1:0] len, input string tag);
    @(negedge clk);
    start_i = st; k0_i = k0; half_step_i = h; step_neg_i = neg; ramp_len_i = len;
    if (st && len != 0) begin
      m_k0 = k0; m_h = h; m_neg = neg; m_len = len; m_idx = '0; m_run = 1'b1;
    end else if (m_run) begin
      if (m_idx == m_len - 1'b1) m_run = 1'b0;
      else m_idx = m_idx + 1'b1;
    end
    q_act.push_back(m_run);
    q_tw.push_back(model_words());
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++)
      drive(1'b0, 32'hA5A5_0000 + 32'(k * 977), 32'(k * 13 + 1), k[0], 16'(k + 3), tag);
  endtask

  // monitor: compares 1 ns after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (q_act.size() > 0) begin
      logic               ea;
      logic [LANES*N-1:0] ew;
      string              tg;
      ea = q_act.pop_front(); ew = q_tw.pop_front(); tg = q_tag.pop_front();
      checks++;
      if (active_o !== ea || tw_o !== ew) begin
        failures++;
        $display("FAIL %s active=%0b/%0b lane0=%h/%h lane7=%h/%h (actual/expected)",
                 tg, active_o, ea, tw_o[0 +: N], ew[0 +: N],
                 tw_o[7*N +: N], ew[7*N +: N]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog active=%0b expected run end", active_o);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 0; k0_i = '0; half_step_i = '0; step_neg_i = 0; ramp_len_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    checks++;
    if (active_o !== 1'b0 || tw_o !== '0) begin
      failures++;
      $display("FAIL R1 active=%0b tw=%h expected 0", active_o, tw_o);
    end
    idle(2, "R1");
    // R2/R3/R5: rising ramp of 5 slow clocks
    drive(1'b1, 32'd1000, 32'd3, 1'b0, 16'd5, "R2");
    idle(4, "R3");
    // R5 end of ramp, R6/R10 hold under wandering inputs
    idle(5, "R6 R10");
    // R4: falling ramp of 4
    drive(1'b1, 32'd50000, 32'd7, 1'b1, 16'd4, "R4");
    idle(3, "R4");
    idle(2, "R5");
    // R9: wrap upward past 2^N
    drive(1'b1, 32'hFFFF_FFF0, 32'd5, 1'b0, 16'd3, "R9");
    idle(4, "R9");
    // R9: wrap downward below 0
    drive(1'b1, 32'd20, 32'd9, 1'b1, 16'd2, "R9");
    idle(3, "R9");
    // R7: restart during an active ramp
    drive(1'b1, 32'h0010_0000, 32'd100, 1'b0, 16'd6, "R7");
    idle(2, "R7");
    drive(1'b1, 32'h0200_0000, 32'd40, 1'b1, 16'd3, "R7");
    idle(4, "R7");
    // R8: zero-length start from idle and during a ramp
    drive(1'b1, 32'h1234_5678, 32'd77, 1'b0, 16'd0, "R8");
    idle(1, "R8");
    drive(1'b1, 32'd7, 32'd1, 1'b0, 16'd3, "R8");
    drive(1'b1, 32'h5555_5555, 32'd99, 1'b1, 16'd0, "R8");
    idle(3, "R8");
    // R10: inputs change every cycle while a long ramp runs
    drive(1'b1, 32'd64, 32'd2, 1'b0, 16'd10, "R10");
    idle(11, "R10");
    // R5: single-cycle ramp
    drive(1'b1, 32'd500, 32'd11, 1'b0, 16'd1, "R5");
    idle(2, "R5");
    while (q_act.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule